// File: doc/BRIEF.md
# Codec Command Ring Fetch Engine

This block feeds codec commands to a link controller. Software keeps a circular ring of 32-bit command words in host memory. It programs the ring base, then advances a write pointer and sets a run bit. The engine steps its 8-bit read pointer forward before each fetch and issues one memory read. It splits the returned word into a codec address, a node number and a 20-bit payload, and offers the result on a valid/ready verb port.

A second source, the immediate-command path, carries a single command word written by software. Writing that word raises a busy flag. While the flag is up the engine sends that word before it starts any new ring fetch. The flag drops once the word has been accepted on the verb port or has been discarded.

Two kinds of word are discarded without being dispatched: words with the indirect-addressing bit set, and words aimed at a codec slot that the codec presence mask marks empty. Ring fetching also pauses while the response count supplied by the response ring equals the programmed limit.

Top module: `cmd_ring_fetch`

## Requirements
- R1: After reset the read pointer is 0, the busy flag is low, and neither a memory request nor a verb is offered.
- R2: Each fetch first increments the read pointer modulo 256. It then requests the address {base_hi, base_lo} + 4 × (new read pointer). After entry 255 the next fetch uses entry 0.
- R3: No fetch starts while the run bit (bit 0 of the run register) is 0.
- R4: No fetch starts while the read pointer equals the write pointer.
- R5: No ring fetch starts while `rsp_count` equals the programmed response limit.
- R6: A dispatched word is split as follows: codec address = bits 31:28, node = bits 26:20, payload = bits 19:0.
- R7: A word with bit 27 set, from the ring or from the immediate path, is discarded and never appears on the verb port. For a ring word the read pointer still advances.
- R8: A word whose codec address selects a 0 bit of `codec_present` is discarded.
- R9: Writing the immediate word sets `imm_busy`. The immediate word is sent, with `verb_imm` = 1, ahead of any ring fetch not yet started. `imm_busy` clears when the word is accepted or discarded.
- R10: At most one memory read is outstanding at a time. A verb held without ready keeps its fields stable, and no further fetch starts until it is accepted.
- R11: A write to the read-pointer clear register sets the read pointer to 0.

Register selects (`cfg_sel`): 0 base low, 1 base high, 2 write pointer (bits 7:0), 3 run (bit 0), 4 response limit (bits 7:0), 5 immediate word, 6 read-pointer clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| rsp_count | input | 8 | Responses counted since last acknowledge |
| codec_present | input | 16 | One bit per codec slot that holds a codec |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 64 | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data (command word) |
| verb_valid | output | 1 | Verb offered |
| verb_ready | input | 1 | Verb accepted |
| verb_cad | output | 4 | Codec address |
| verb_nid | output | 7 | Node number |
| verb_payload | output | 20 | Verb payload |
| verb_imm | output | 1 | Verb came from the immediate path |
| rd_ptr | output | 8 | Current read pointer |
| imm_busy | output | 1 | Immediate word pending |

## Verification
The immediate path and the ring path compete for the same verb port, so the bench makes them land together. It stalls verb ready while a ring verb is held. It then writes an immediate word and moves the write pointer forward in the same window, and releases ready. The scoreboard queue holds the expected order: the held ring verb first, then the immediate verb, then the later ring entries. Any reordering, loss or duplicate shows up as a mismatch.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;
   localparam int VERB_W    = 32;
   localparam int CAD_W     = 4;
   localparam int NID_W     = 7;
   localparam int PAY_W     = 20;
   localparam int CAD_LSB   = 28;
   localparam int IND_BIT   = 27;
   localparam int NID_LSB   = 20;
   localparam int NUM_CODEC = 1 << CAD_W;

   typedef enum logic [2:0] {
      SEL_BASE_LO   = 3'd0,
      SEL_BASE_HI   = 3'd1,
      SEL_WR_PTR    = 3'd2,
      SEL_RUN       = 3'd3,
      SEL_RSP_LIMIT = 3'd4,
      SEL_IMM_CMD   = 3'd5,
      SEL_RP_CLEAR  = 3'd6
   } cfg_sel_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2,
      ST_SEND = 2'd3
   } seq_state_e;

   typedef struct packed {
      logic [CAD_W-1:0] cad;
      logic [NID_W-1:0] nid;
      logic [PAY_W-1:0] payload;
   } verb_t;
endpackage

// File: rtl/crf_regs.sv
module crf_regs
   import cmd_ring_pkg::*;
#(
   parameter int REG_W = 32,
   parameter int PTR_W = 8,
   parameter int CNT_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [2:0]         cfg_sel,
   input  logic [REG_W-1:0]   cfg_wdata,
   input  logic               imm_done,
   output logic [2*REG_W-1:0] base_addr,
   output logic [PTR_W-1:0]   wr_ptr,
   output logic               run_en,
   output logic [CNT_W-1:0]   rsp_limit,
   output logic [VERB_W-1:0]  imm_word,
   output logic               imm_busy,
   output logic               rp_clear
);
   logic [REG_W-1:0] base_lo_q, base_hi_q;

   if (PTR_W > REG_W) begin : g_bad_ptr
      $error("PTR_W must fit in a register");
   end
   if (CNT_W > REG_W) begin : g_bad_cnt
      $error("CNT_W must fit in a register");
   end
   if (VERB_W > REG_W) begin : g_bad_verb
      $error("command word must fit in a register");
   end

   assign base_addr = {base_hi_q, base_lo_q};
   assign rp_clear  = cfg_we && (cfg_sel == SEL_RP_CLEAR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_lo_q <= '0;
         base_hi_q <= '0;
         wr_ptr    <= '0;
         run_en    <= 1'b0;
         rsp_limit <= '0;
         imm_word  <= '0;
      end else if (cfg_we) begin
         case (cfg_sel)
            SEL_BASE_LO:   base_lo_q <= cfg_wdata;
            SEL_BASE_HI:   base_hi_q <= cfg_wdata;
            SEL_WR_PTR:    wr_ptr    <= cfg_wdata[PTR_W-1:0];
            SEL_RUN:       run_en    <= cfg_wdata[0];
            SEL_RSP_LIMIT: rsp_limit <= cfg_wdata[CNT_W-1:0];
            SEL_IMM_CMD:   imm_word  <= cfg_wdata[VERB_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         imm_busy <= 1'b0;
      else if (cfg_we && (cfg_sel == SEL_IMM_CMD))
         imm_busy <= 1'b1;
      else if (imm_done)
         imm_busy <= 1'b0;
   end

   assert_imm_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == SEL_IMM_CMD) |=> imm_busy)
      else $error("immediate write did not raise busy");
endmodule

// File: rtl/crf_filter.sv
module crf_filter
   import cmd_ring_pkg::*;
#(
   parameter bit CHECK_PRESENCE = 1'b1
) (
   input  logic [VERB_W-1:0]    raw,
   input  logic [NUM_CODEC-1:0] present,
   output verb_t                fields,
   output logic                 keep
);
   assign fields.cad     = raw[CAD_LSB +: CAD_W];
   assign fields.nid     = raw[NID_LSB +: NID_W];
   assign fields.payload = raw[PAY_W-1:0];

   if (CHECK_PRESENCE) begin : g_presence
      assign keep = !raw[IND_BIT] && present[fields.cad];
   end else begin : g_no_presence
      logic unused_present;
      assign unused_present = ^present;
      assign keep = !raw[IND_BIT];
   end
endmodule

// File: rtl/crf_seq.sv
module crf_seq
   import cmd_ring_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int PTR_W  = 8,
   parameter int CNT_W  = 8,
   parameter int ENTRY_LOG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  logic              run_en,
   input  logic [CNT_W-1:0]  rsp_limit,
   input  logic [CNT_W-1:0]  rsp_count,
   input  logic              rp_clear,
   input  logic              imm_busy,
   input  verb_t             imm_fields,
   input  logic              imm_keep,
   input  verb_t             mem_fields,
   input  logic              mem_keep,
   output logic              imm_done,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   output logic              verb_valid,
   input  logic              verb_ready,
   output verb_t             verb_out,
   output logic              verb_imm,
   output logic [PTR_W-1:0]  rd_ptr
);
   localparam int PAD_W = ADDR_W - PTR_W - ENTRY_LOG2;

   if (PAD_W < 0) begin : g_bad_addr
      $error("address too narrow for ring offset");
   end

   seq_state_e       state_q;
   logic [PTR_W-1:0] rp_nxt;
   logic [ADDR_W-1:0] entry_off;
   logic             fetch_ok;

   assign rp_nxt    = rd_ptr + 1'b1;
   assign entry_off = {{PAD_W{1'b0}}, rp_nxt, {ENTRY_LOG2{1'b0}}};
   assign fetch_ok  = run_en && (rd_ptr != wr_ptr) && (rsp_count != rsp_limit);

   assign mem_req_valid = (state_q == ST_REQ);
   assign verb_valid    = (state_q == ST_SEND);
   assign imm_done = ((state_q == ST_IDLE) && imm_busy && !imm_keep) ||
                     ((state_q == ST_SEND) && verb_ready && verb_imm);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         rd_ptr       <= '0;
         mem_req_addr <= '0;
         verb_out     <= '0;
         verb_imm     <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (imm_busy) begin
                  if (imm_keep) begin
                     verb_out <= imm_fields;
                     verb_imm <= 1'b1;
                     state_q  <= ST_SEND;
                  end
               end else if (fetch_ok) begin
                  rd_ptr       <= rp_nxt;
                  mem_req_addr <= base_addr + entry_off;
                  state_q      <= ST_REQ;
               end
            end
            ST_REQ: begin
               if (mem_req_ready) state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  if (mem_keep) begin
                     verb_out <= mem_fields;
                     verb_imm <= 1'b0;
                     state_q  <= ST_SEND;
                  end else begin
                     state_q  <= ST_IDLE;
                  end
               end
            end
            ST_SEND: begin
               if (verb_ready) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
         if (rp_clear) rd_ptr <= '0;
      end
   end

   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)))
      else $error("request dropped or changed while stalled");

   assert_verb_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (verb_valid && !verb_ready) |=> (verb_valid && $stable(verb_out) && $stable(verb_imm)))
      else $error("verb dropped or changed while stalled");

   assert_run_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> $past(run_en))
      else $error("fetch started with run clear");

   assert_empty_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> ($past(rd_ptr) != $past(wr_ptr)))
      else $error("fetch started on empty ring");

   assert_limit_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> ($past(rsp_count) != $past(rsp_limit)))
      else $error("fetch started at response limit");

   assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_req_valid) && !$past(rp_clear)) |->
         (mem_req_addr == $past(base_addr) + {{PAD_W{1'b0}}, rd_ptr, {ENTRY_LOG2{1'b0}}}))
      else $error("fetch address does not match read pointer");

   assert_imm_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> !$past(imm_busy))
      else $error("ring fetch started ahead of pending immediate word");
endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
   import cmd_ring_pkg::*;
#(
   parameter int REG_W = 32,
   parameter int PTR_W = 8,
   parameter int CNT_W = 8,
   parameter bit CHECK_PRESENCE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [2:0]           cfg_sel,
   input  logic [REG_W-1:0]     cfg_wdata,
   input  logic [CNT_W-1:0]     rsp_count,
   input  logic [NUM_CODEC-1:0] codec_present,
   output logic                 mem_req_valid,
   input  logic                 mem_req_ready,
   output logic [2*REG_W-1:0]   mem_req_addr,
   input  logic                 mem_rsp_valid,
   input  logic [VERB_W-1:0]    mem_rsp_data,
   output logic                 verb_valid,
   input  logic                 verb_ready,
   output logic [CAD_W-1:0]     verb_cad,
   output logic [NID_W-1:0]     verb_nid,
   output logic [PAY_W-1:0]     verb_payload,
   output logic                 verb_imm,
   output logic [PTR_W-1:0]     rd_ptr,
   output logic                 imm_busy
);
   localparam int ADDR_W = 2 * REG_W;

   logic [ADDR_W-1:0] base_addr;
   logic [PTR_W-1:0]  wr_ptr;
   logic              run_en, rp_clear, imm_done, imm_keep, mem_keep;
   logic [CNT_W-1:0]  rsp_limit;
   logic [VERB_W-1:0] imm_word;
   verb_t             imm_fields, mem_fields, verb_out;

   crf_regs #(.REG_W(REG_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .imm_done(imm_done), .base_addr(base_addr),
      .wr_ptr(wr_ptr), .run_en(run_en), .rsp_limit(rsp_limit),
      .imm_word(imm_word), .imm_busy(imm_busy), .rp_clear(rp_clear)
   );

   crf_filter #(.CHECK_PRESENCE(CHECK_PRESENCE)) u_imm_filter (
      .raw(imm_word), .present(codec_present), .fields(imm_fields), .keep(imm_keep)
   );

   crf_filter #(.CHECK_PRESENCE(CHECK_PRESENCE)) u_mem_filter (
      .raw(mem_rsp_data), .present(codec_present), .fields(mem_fields), .keep(mem_keep)
   );

   crf_seq #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .wr_ptr(wr_ptr),
      .run_en(run_en), .rsp_limit(rsp_limit), .rsp_count(rsp_count),
      .rp_clear(rp_clear), .imm_busy(imm_busy), .imm_fields(imm_fields),
      .imm_keep(imm_keep), .mem_fields(mem_fields), .mem_keep(mem_keep),
      .imm_done(imm_done), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .verb_valid(verb_valid),
      .verb_ready(verb_ready), .verb_out(verb_out), .verb_imm(verb_imm),
      .rd_ptr(rd_ptr)
   );

   assign verb_cad     = verb_out.cad;
   assign verb_nid     = verb_out.nid;
   assign verb_payload = verb_out.payload;

   if (CHECK_PRESENCE) begin : g_present_chk
      assert_present_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (verb_valid && $rose(verb_valid)) |-> codec_present[verb_cad])
         else $error("verb sent to an empty codec slot");
   end
endmodule

// File: tb/cmd_ring_fetch_bench.sv
module cmd_ring_fetch_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic [7:0]  rsp_count = '0;
   logic [15:0] codec_present = 16'hFFF7;
   logic        mem_req_valid, mem_req_ready;
   logic [63:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        verb_valid, verb_imm, imm_busy;
   logic        verb_ready = 1'b1;
   logic [3:0]  verb_cad;
   logic [6:0]  verb_nid;
   logic [19:0] verb_payload;
   logic [7:0]  rd_ptr;

   int total = 0;
   int bad = 0;
   int req_count = 0;
   int sw_wp = 0;
   int model_rp = 0;
   bit hold = 1'b0;
   bit stall_mode = 1'b0;
   logic [63:0] base = 64'h0000_0002_1000_0040;
   logic [31:0] sb_q[$];

   always #2.5 clk = ~clk;

   assign mem_req_ready = 1'b1;

   cmd_ring_fetch u_cmd_ring_fetch (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .rsp_count(rsp_count), .codec_present(codec_present),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .verb_valid(verb_valid), .verb_ready(verb_ready),
      .verb_cad(verb_cad), .verb_nid(verb_nid), .verb_payload(verb_payload),
      .verb_imm(verb_imm), .rd_ptr(rd_ptr), .imm_busy(imm_busy)
   );

   function automatic logic [31:0] ent(input int i);
      logic [7:0] b;
      logic ind;
      b = i[7:0];
      ind = ((i % 7) == 2);
      return {b[3:0], ind, b[6:0] ^ 7'h2A, b, ~b, 4'h5};
   endfunction

   function automatic bit kept(input logic [31:0] v);
      return !v[27] && codec_present[v[31:28]];
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic set_wp(input int nw);
      int k;
      k = sw_wp;
      while (k != nw) begin
         k = (k + 1) % 256;
         if (kept(ent(k))) begin
            logic [31:0] v;
            v = ent(k);
            sb_q.push_back({1'b0, v[31:28], v[26:20], v[19:0]});
         end
      end
      sw_wp = nw;
      cfg_write(3'd2, nw);
   endtask

   task automatic send_imm(input logic [31:0] v);
      if (kept(v)) sb_q.push_back({1'b1, v[31:28], v[26:20], v[19:0]});
      cfg_write(3'd5, v);
   endtask

   // verb ready driver
   initial forever begin
      @(posedge clk); #1;
      verb_ready = hold ? 1'b0 : (stall_mode ? ~verb_ready : 1'b1);
   end

   // memory model with fetch-address check (R2)
   initial forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid && mem_req_ready) begin
         logic [63:0] off;
         int idx;
         off = mem_req_addr - base;
         idx = int'(off[9:2]);
         model_rp = (model_rp + 1) % 256;
         req_count++;
         check(off[1:0] == 2'b00 && off[63:10] == '0 && idx == model_rp,
               "R2 fetch address", mem_req_addr, base + 64'(4 * model_rp));
         @(posedge clk); #1;
         mem_rsp_valid = 1'b1;
         mem_rsp_data  = ent(idx);
         @(posedge clk); #1;
         mem_rsp_valid = 1'b0;
      end
   end

   // scoreboard monitor (R6 field split, R9 order, R10 no loss)
   initial forever begin
      @(negedge clk);
      if (rst_n && verb_valid && verb_ready) begin
         logic [31:0] got;
         got = {verb_imm, verb_cad, verb_nid, verb_payload};
         if (sb_q.size() == 0) begin
            check(1'b0, "R7 R8 unexpected verb", got, 0);
         end else begin
            logic [31:0] exp;
            exp = sb_q.pop_front();
            check(got == exp, "R6 R9 verb fields/order", got, exp);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(rd_ptr == 0, "R1 reset rd_ptr", rd_ptr, 0);
      check(!mem_req_valid && !verb_valid, "R1 reset idle",
            {mem_req_valid, verb_valid}, 0);
      check(!imm_busy, "R1 reset busy", imm_busy, 0);

      cfg_write(3'd0, base[31:0]);
      cfg_write(3'd1, base[63:32]);
      cfg_write(3'd4, 8);
      cfg_write(3'd3, 1);
      set_wp(3);                           // entry 2 indirect, entry 3 absent codec
      repeat (40) @(posedge clk);
      @(negedge clk);
      check(rd_ptr == 3, "R4 stops at write pointer", rd_ptr, 3);
      check(req_count == 3, "R7 R8 dropped entries still fetched", req_count, 3);
      check(sb_q.size() == 0, "R7 R8 only kept verbs", sb_q.size(), 0);

      cfg_write(3'd3, 0);
      set_wp(6);
      repeat (30) @(posedge clk);
      @(negedge clk);
      check(rd_ptr == 3, "R3 halted with run clear", rd_ptr, 3);
      cfg_write(3'd3, 1);
      repeat (40) @(posedge clk);
      @(negedge clk);
      check(rd_ptr == 6, "R3 resumes with run set", rd_ptr, 6);

      rsp_count = 8'd4;
      cfg_write(3'd4, 4);
      set_wp(8);
      repeat (30) @(posedge clk);
      @(negedge clk);
      check(rd_ptr == 6, "R5 halted at response limit", rd_ptr, 6);
      rsp_count = 8'd0;
      repeat (40) @(posedge clk);
      @(negedge clk);
      check(rd_ptr == 8, "R5 resumes below limit", rd_ptr, 8);

      hold = 1'b1;
      set_wp(10);
      repeat (30) @(posedge clk);
      @(negedge clk);
      check(verb_valid && !verb_imm, "R10 ring verb held", {verb_valid, verb_imm}, 2'b10);
      send_imm({4'd5, 1'b0, 7'h11, 20'hABCDE});
      set_wp(12);
      repeat (10) @(posedge clk);
      @(negedge clk);
      check(imm_busy, "R9 busy while pending", imm_busy, 1);
      check(rd_ptr == 10, "R10 no fetch while verb held", rd_ptr, 10);
      hold = 1'b0;
      repeat (60) @(posedge clk);
      @(negedge clk);
      check(!imm_busy, "R9 busy cleared", imm_busy, 0);
      check(rd_ptr == 12, "R9 ring resumes after immediate", rd_ptr, 12);

      send_imm({4'd6, 1'b1, 7'h22, 20'h12345});
      repeat (20) @(posedge clk);
      @(negedge clk);
      check(!imm_busy, "R7 indirect immediate discarded", imm_busy, 0);

      cfg_write(3'd3, 0);
      repeat (5) @(posedge clk);
      model_rp = 0;
      cfg_write(3'd6, 0);
      @(negedge clk);
      check(rd_ptr == 0, "R11 read pointer cleared", rd_ptr, 0);
      sw_wp = 0;
      set_wp(2);
      cfg_write(3'd3, 1);
      repeat (40) @(posedge clk);
      @(negedge clk);
      check(rd_ptr == 2, "R11 refetch from start", rd_ptr, 2);

      stall_mode = 1'b1;
      set_wp(255);
      repeat (3000) @(posedge clk);
      @(negedge clk);
      check(rd_ptr == 255, "R2 last entry", rd_ptr, 255);
      set_wp(1);
      repeat (60) @(posedge clk);
      @(negedge clk);
      check(rd_ptr == 1, "R2 wrap to entry 0", rd_ptr, 1);
      check(sb_q.size() == 0, "R10 all verbs delivered", sb_q.size(), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule